// File: doc/BRIEF.md
# Dual-Requester Bus Arbiter with Timeout

This block shares one external memory bus between two memory controllers: a dynamic-memory port and a static-memory port. A requester that is granted the bus keeps it for as long as it holds its request. A request from the other side is held off meanwhile. Neither controller can starve the other: once the non-owner has been kept waiting for a bounded number of cycles, the owner loses its grant and the bus moves to the waiting side.

While the dynamic-memory port owns the bus, the waiting limit is fixed at 1024 cycles. While the static-memory port owns it, the limit comes from an 8-bit setting held in a small register, reached through a plain read/write port. Bit 7 of the setting is replicated into the top three bits of the 10-bit count, and bits 6..0 fill the low bits. Setting it to 0x01 makes the static side yield almost at once. In effect this gives the dynamic side priority, for example when a display engine streams from dynamic memory.

Top module: `dual_bus_arbiter`

## Requirements
- R1: After reset both grants are low. A grant never rises for both ports in the same cycle.
- R2: On an idle bus, a request is granted at the next rising edge. When both requests are present together, the dynamic port (gnt_dyn) wins.
- R3: An owner that keeps its request keeps its grant, and the other port stays ungranted, until the timeout expires.
- R4: While the dynamic port owns the bus and both requests are high, gnt_dyn falls at the 1024th consecutive rising edge that sees the conflict.
- R5: While the static port owns the bus, it loses gnt_sta at the N-th consecutive conflict edge. N = {s[7],s[7],s[7],s[6:0]} + 1, where s is the 8-bit setting, so 0xFF gives 1024 and 0x01 gives 2.
- R6: After a forced release, both grants are low for exactly one cycle. The waiter is then granted.
- R7: When an owner drops its request while the other request is high, the grant passes to the other port at the next rising edge.
- R8: If the waiting request drops before expiry, the count is discarded. The next conflict gets the full limit again.
- R9: The setting sits at byte address 0x50. A read there returns {24'h0, s}, and any other address reads 0. Write bits 31..8 are ignored.
- R10: The setting resets to 0xFF. A write whose low byte is 0x00 leaves the setting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_dyn | input | 1 | Bus request from the dynamic-memory controller |
| req_sta | input | 1 | Bus request from the static-memory controller |
| gnt_dyn | output | 1 | Bus grant to the dynamic-memory controller |
| gnt_sta | output | 1 | Bus grant to the static-memory controller |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |

## Verification
Grants are registered state, so a request change driven on a falling edge first shows on the grants after the next rising edge. The bench samples 1 ns after that edge. A timeout is measured by counting rising edges, from the edge that first sees the conflict to the edge after which the owner's grant is low. The count is compared with the limit worked out from the setting (1024 for the dynamic side). The gap state is checked at that same edge and the waiter's grant one edge later. Register writes take effect at the strobed rising edge, while reads are combinational, so readback is checked within the following low phase.

// File: rtl/arb_pkg.sv
// Shared types for the dual-requester bus arbiter.
package arb_pkg;

    // Bus ownership state; the gap states are the dead cycle of a forced hand-over.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DYN      = 3'd1,
        ST_STA      = 3'd2,
        ST_GAP_DYN  = 3'd3,   // forced off the static side, dynamic next
        ST_GAP_STA  = 3'd4    // forced off the dynamic side, static next
    } arb_state_t;

endpackage

// File: rtl/arb_timeout_reg.sv
// Holds the 8-bit static-side timeout setting behind a simple register port.
// Assumes byte addressing; only the low byte of the word is implemented and
// a zero low byte is never stored, so the setting is always non-zero.
module arb_timeout_reg #(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SLOT_ADDR = 8'h50,
    parameter logic [7:0]      SLOT_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [7:0]        setting
);

    localparam int PAD_W = DATA_W - 8;

    logic hit;
    logic take;
    logic unused_hi;

    assign hit       = (addr == SLOT_ADDR);
    assign take      = wr && hit && (wdata[7:0] != 8'h00);
    assign unused_hi = ^wdata[DATA_W-1:8];

    // Setting register: reset value, then accept only non-zero low bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setting <= SLOT_RST;
        end else if (take) begin
            setting <= wdata[7:0];
        end
    end

    // Read path: zero-extended setting at its slot, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata = {{PAD_W{1'b0}}, setting};
        end
    end

    a_r10_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        setting != 8'h00);

    a_r10_zero_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit && wdata[7:0] == 8'h00) |=> $stable(setting));

endmodule

// File: rtl/arb_timeout_ctr.sv
// Counts consecutive cycles in which the non-owner is kept waiting.
// Loads the limit minus one on the first conflict edge, counts down on each
// further one, and flags expiry on the edge that completes the limit.
// Assumes load_val >= 1; clear (a change of owner) or a lapse in the
// conflict discards the count.
module arb_timeout_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conflict,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // Countdown register with its armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (clear || !conflict) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            active <= 1'b1;
            cnt    <= load_val;
        end else begin
            cnt    <= cnt - 1'b1;
        end
    end

    // Expiry: the current edge is the last one the waiter has to sit through.
    assign expire = conflict && active && (cnt == {{(CNT_W-1){1'b0}}, 1'b1});

    a_r8_restart_on_lapse: assert property (@(posedge clk) disable iff (!rst_n)
        (!conflict) |=> !active);

    a_r4_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (active && conflict && !clear) |=> (cnt == $past(cnt) - 1'b1));

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt != '0));

endmodule

// File: rtl/arb_fsm.sv
// Ownership state machine for the two requesters.
// Idle bus: the dynamic side wins ties. An owner keeps the bus while it
// requests; a voluntary release passes it straight to a waiter; an expiry
// passes it through one dead cycle. Grants decode the registered state.
module arb_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_dyn,
    input  logic req_sta,
    input  logic expire,
    output logic gnt_dyn,
    output logic gnt_sta,
    output logic conflict,
    output logic change
);

    arb_state_t state;
    arb_state_t state_nx;

    // Next-state choice for the current owner and requests.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (req_dyn)      state_nx = ST_DYN;
                else if (req_sta) state_nx = ST_STA;
            end
            ST_DYN: begin
                if (!req_dyn)     state_nx = req_sta ? ST_STA : ST_IDLE;
                else if (expire)  state_nx = ST_GAP_STA;
            end
            ST_STA: begin
                if (!req_sta)     state_nx = req_dyn ? ST_DYN : ST_IDLE;
                else if (expire)  state_nx = ST_GAP_DYN;
            end
            ST_GAP_STA: begin
                if (req_sta)      state_nx = ST_STA;
                else if (req_dyn) state_nx = ST_DYN;
                else              state_nx = ST_IDLE;
            end
            ST_GAP_DYN: begin
                if (req_dyn)      state_nx = ST_DYN;
                else if (req_sta) state_nx = ST_STA;
                else              state_nx = ST_IDLE;
            end
            default:              state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Decode grants and the conflict and hand-over strobes for the counter.
    always_comb begin
        gnt_dyn  = (state == ST_DYN);
        gnt_sta  = (state == ST_STA);
        conflict = req_dyn && req_sta && (gnt_dyn || gnt_sta);
        change   = (state_nx != state);
    end

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_dyn && gnt_sta));

    a_r2_tie_to_dyn: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_dyn) |=> gnt_dyn);

    a_r6_dead_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_dyn || gnt_sta) && req_dyn && req_sta && expire) |=> (!gnt_dyn && !gnt_sta));

    a_r7_voluntary_dyn: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_dyn && !req_dyn && req_sta) |=> gnt_sta);

    a_r3_hold_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_sta && req_sta && !expire) |=> gnt_sta);

endmodule

// File: rtl/dual_bus_arbiter.sv
// Top level: shares one bus between a dynamic-memory and a static-memory
// controller, with a waiting-time limit on each owner. The dynamic owner's
// limit is fixed; the static owner's comes from an 8-bit register whose
// top bit is replicated into the upper counter bits.
module dual_bus_arbiter #(
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 32,
    parameter int              CNT_W       = 10,
    parameter int              DYN_TIMEOUT = 1024,
    parameter logic [ADDR_W-1:0] SLOT_ADDR = 8'h50,
    parameter logic [7:0]      SLOT_RST    = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_dyn,
    input  logic              req_sta,
    output logic              gnt_dyn,
    output logic              gnt_sta,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata
);

    localparam int               HI_W     = CNT_W - 7;
    localparam logic [CNT_W-1:0] DYN_LOAD = CNT_W'(DYN_TIMEOUT - 1);

    logic [7:0]       setting;
    logic [CNT_W-1:0] sta_load;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic             conflict;
    logic             change;

    // Widen the setting: bit 7 fills all upper counter bits.
    assign sta_load = {{HI_W{setting[7]}}, setting[6:0]};
    // Limit of whichever side owns the bus now.
    assign load_val = gnt_sta ? sta_load : DYN_LOAD;

    arb_timeout_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SLOT_ADDR (SLOT_ADDR),
        .SLOT_RST  (SLOT_RST)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .setting (setting)
    );

    arb_timeout_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .conflict (conflict),
        .clear    (change),
        .load_val (load_val),
        .expire   (expire)
    );

    arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_dyn  (req_dyn),
        .req_sta  (req_sta),
        .expire   (expire),
        .gnt_dyn  (gnt_dyn),
        .gnt_sta  (gnt_sta),
        .conflict (conflict),
        .change   (change)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        (!rst_n) |=> (!gnt_dyn && !gnt_sta));

endmodule

// File: tb/tb_dual_bus_arbiter.sv
module tb_dual_bus_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_dyn = 1'b0;
    logic        req_sta = 1'b0;
    logic        gnt_dyn;
    logic        gnt_sta;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_bus_arbiter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_dyn   (req_dyn),
        .req_sta   (req_sta),
        .gnt_dyn   (gnt_dyn),
        .gnt_sta   (gnt_sta),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sta_limit(input logic [7:0] s);
        return int'({s[7], s[7], s[7], s[6:0]}) + 1;
    endfunction

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, req, int'(cfg_rdata), int'(exp));
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_dyn = 1'b0; req_sta = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check(!gnt_dyn && !gnt_sta, "R1", int'({gnt_dyn, gnt_sta}), 0);
    endtask

    task automatic take(input bit dyn);
        @(negedge clk);
        if (dyn) req_dyn = 1'b1; else req_sta = 1'b1;
        @(posedge clk); #1;
        if (dyn) check(gnt_dyn && !gnt_sta, "R2", int'({gnt_dyn, gnt_sta}), 2);
        else     check(gnt_sta && !gnt_dyn, "R2", int'({gnt_dyn, gnt_sta}), 1);
    endtask

    // Owner is granted; raise the other request and count edges to release.
    task automatic timeout_run(input bit dyn_owner, input int exp, input string req);
        int n = 0;
        bit held_ok = 1'b1;
        @(negedge clk);
        if (dyn_owner) req_sta = 1'b1; else req_dyn = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            n++;
            if (dyn_owner ? !gnt_dyn : !gnt_sta) break;
            if (dyn_owner ? gnt_sta : gnt_dyn) held_ok = 1'b0;
        end
        check(n == exp, req, n, exp);
        check(held_ok, "R3", int'(held_ok), 1);
        check(!gnt_dyn && !gnt_sta, "R6 gap", int'({gnt_dyn, gnt_sta}), 0);
        @(posedge clk); #1;
        if (dyn_owner) check(gnt_sta && !gnt_dyn, "R6 handover", int'({gnt_dyn, gnt_sta}), 1);
        else           check(gnt_dyn && !gnt_sta, "R6 handover", int'({gnt_dyn, gnt_sta}), 2);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] sweep [6] = '{8'h01, 8'h02, 8'h7F, 8'h80, 8'hC3, 8'hFF};
        repeat (3) @(posedge clk);
        #1;
        check(!gnt_dyn && !gnt_sta, "R1 reset", int'({gnt_dyn, gnt_sta}), 0);
        @(negedge clk); rst_n = 1'b1;

        // R10 / R9: reset value, address decode, masking, zero write.
        read_chk(8'h50, 32'h0000_00FF, "R10 reset value");
        read_chk(8'h54, 32'h0, "R9 other address");
        write_reg(8'h50, 32'hABCD_1234);
        read_chk(8'h50, 32'h0000_0034, "R9 upper bits ignored");
        write_reg(8'h50, 32'hFFFF_FF00);
        read_chk(8'h50, 32'h0000_0034, "R10 zero write ignored");
        write_reg(8'h40, 32'h0000_0077);
        read_chk(8'h50, 32'h0000_0034, "R9 write elsewhere");

        // R2 tie on idle bus.
        @(negedge clk); req_dyn = 1'b1; req_sta = 1'b1;
        @(posedge clk); #1;
        check(gnt_dyn && !gnt_sta, "R2 tie", int'({gnt_dyn, gnt_sta}), 2);
        go_idle();

        // R4 fixed dynamic-side limit.
        take(1'b1);
        timeout_run(1'b1, 1024, "R4");
        go_idle();

        // R5 sweep of static-side settings.
        foreach (sweep[k]) begin
            write_reg(8'h50, {24'h0, sweep[k]});
            take(1'b0);
            timeout_run(1'b0, sta_limit(sweep[k]), "R5");
            go_idle();
        end

        // R8: waiter withdraws part-way, full limit applies afterwards.
        take(1'b1);
        @(negedge clk); req_sta = 1'b1;
        repeat (500) @(posedge clk);
        @(negedge clk); req_sta = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        check(gnt_dyn, "R8 still owner", int'(gnt_dyn), 1);
        timeout_run(1'b1, 1024, "R8");
        go_idle();

        // R7: voluntary release passes straight to the waiter.
        take(1'b1);
        @(negedge clk); req_sta = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); req_dyn = 1'b0;
        @(posedge clk); #1;
        check(gnt_sta && !gnt_dyn, "R7 dyn to sta", int'({gnt_dyn, gnt_sta}), 1);
        @(negedge clk); req_dyn = 1'b1; req_sta = 1'b0;
        @(posedge clk); #1;
        check(gnt_dyn && !gnt_sta, "R7 sta to dyn", int'({gnt_dyn, gnt_sta}), 2);
        go_idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule